// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block provides two 8-bit digital ports behind a small synchronous register bus. Port A is bidirectional. Each of its pins has an output latch bit and a direction bit. Port B is input-only. Port B pin levels are read through a synchronizer, and port B has no direction control.

Converter logic can take over some port A pins through mode inputs:
- With external multiplexer mode enabled, pins 2:0 become outputs. They carry the converter's multiplexer address, and a data read of those bits returns that address.
- With a trigger mode enabled, pin 3 (trigger 1) or pin 4 (trigger 2) is forced to be an input. A data read of that bit returns the synchronized pin level, and the level is also passed to the converter.

The block drives pad output-enable and input-enable signals. It does not model analog sampling, queue sequencing or pad electrical behaviour.

Bus access works as follows. A write takes effect on the clock edge where `req_i` and `we_i` are both high. A read registers its data into `rdata_o` on the clock edge where `req_i` is high and `we_i` is low. `rdata_o` holds its value at all other times. The offsets are:

| Offset | Register |
|--------|----------|
| 0 | Port A data |
| 1 | Port A direction |
| 2 | Port B data |
| 3 | Unused |

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the port A latch and the port A direction register are zero, `pa_oe_o` is zero and `rdata_o` is zero.
- R2: Direction bit i = 1 makes port A pin i an output (`pa_oe_o[i]`=1, `pa_out_o[i]`=latch bit). Direction bit i = 0 makes pin i an input, unless a mode overrides it.
- R3: Direction bits 7:5 are reserved. They read as zero, writes to them are dropped, and `pa_oe_o[7:5]` is never set.
- R4: A write to offset 0 always updates the output latch, even for pins that are inputs. `pa_out_o` shows the latch on non-mux pins, so a later direction change drives the stored value.
- R5: A read of offset 0 returns the latch bit for output pins. For input pins it returns the pin level passed through a two-flop synchronizer.
- R6: While `ext_mux_en_i` is 1, pins 2:0 are outputs driven from `mux_addr_i`, whatever the direction bits. Read bits 2:0 return `mux_addr_i`.
- R7: While `trig1_en_i` is 1, pin 3 is an input whatever its direction bit. Read bit 3 returns the synchronized pin level, and `trig1_o` carries that level. `trig1_o` is 0 when the mode is off.
- R8: While `trig2_en_i` is 1, pin 4 is an input whatever its direction bit. Read bit 4 returns the synchronized pin level, and `trig2_o` carries that level. `trig2_o` is 0 when the mode is off.
- R9: A read of offset 2 returns the synchronized port B pins. Writes to offset 2 change no register and no output.
- R10: `pa_ie_o` is the bitwise complement of `pa_oe_o` at all times.
- R11: A read of offset 3 returns zero. `rdata_o` changes only on a read edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ext_mux_en_i | input | 1 | External multiplexer mode enable |
| mux_addr_i | input | 3 | Multiplexer address from the converter |
| trig1_en_i | input | 1 | Trigger 1 mode enable (pin 3) |
| trig2_en_i | input | 1 | Trigger 2 mode enable (pin 4) |
| trig1_o | output | 1 | Synchronized trigger 1 level |
| trig2_o | output | 1 | Synchronized trigger 2 level |
| pa_in_i | input | 8 | Port A pad input levels |
| pa_out_o | output | 8 | Port A pad output values |
| pa_oe_o | output | 8 | Port A pad output enables |
| pa_ie_o | output | 8 | Port A pad input enables |
| pb_in_i | input | 8 | Port B pad input levels |

## Verification
The hardest case to reach is a pin whose direction bit says output while a mode claims it. The read must then return either the multiplexer address or the live pin level, and never the stored latch. To reach this, the stimulus writes the direction register with random values that often set bits 4:0. It fills the latch with values that differ from the pin levels, and only then turns the modes on. A directed sequence also stores a latch value while the pins are inputs and then flips the direction bits, checking that the stored value appears on the pads.

// File: rtl/gpio_mux_port_pkg.sv
package gpio_mux_port_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFS_PA_DATA = 2'd0,
    OFS_PA_DIR  = 2'd1,
    OFS_PB_DATA = 2'd2,
    OFS_UNUSED  = 2'd3
  } port_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pa_pinmux.sv
module gpio_pa_pinmux #(
  parameter int unsigned W         = 8,
  parameter int unsigned MUX_BITS  = 3,
  parameter int unsigned TRIG1_BIT = 3,
  parameter int unsigned TRIG2_BIT = 4
) (
  input  logic [W-1:0]        dir_i,
  input  logic [W-1:0]        lat_i,
  input  logic [W-1:0]        sync_i,
  input  logic                ext_mux_en_i,
  input  logic [MUX_BITS-1:0] mux_addr_i,
  input  logic                trig1_en_i,
  input  logic                trig2_en_i,
  output logic [W-1:0]        oe_o,
  output logic [W-1:0]        out_o,
  output logic [W-1:0]        ie_o,
  output logic [W-1:0]        rd_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic mux_own, mux_val, trig_own;

    if (i < MUX_BITS) begin : g_mux
      assign mux_own = ext_mux_en_i;
      assign mux_val = mux_addr_i[i];
    end else begin : g_nomux
      assign mux_own = 1'b0;
      assign mux_val = 1'b0;
    end

    if (i == TRIG1_BIT) begin : g_t1
      assign trig_own = trig1_en_i;
    end else if (i == TRIG2_BIT) begin : g_t2
      assign trig_own = trig2_en_i;
    end else begin : g_tn
      assign trig_own = 1'b0;
    end

    // mode ownership overrides direction
    assign oe_o[i]  = mux_own | (dir_i[i] & ~trig_own);
    assign out_o[i] = mux_own ? mux_val : lat_i[i];
    assign ie_o[i]  = ~oe_o[i];
    assign rd_o[i]  = mux_own ? mux_val :
                      (trig_own | ~dir_i[i]) ? sync_i[i] : lat_i[i];
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_port_pkg::*;
#(
  parameter int unsigned   MUX_BITS  = 3,
  parameter int unsigned   TRIG1_BIT = 3,
  parameter int unsigned   TRIG2_BIT = 4,
  parameter int unsigned   SYNC_STG  = 2,
  parameter logic [7:0]    DIR_MASK  = 8'h1F
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [PORT_W-1:0]   wdata_i,
  output logic [PORT_W-1:0]   rdata_o,
  input  logic                ext_mux_en_i,
  input  logic [MUX_BITS-1:0] mux_addr_i,
  input  logic                trig1_en_i,
  input  logic                trig2_en_i,
  output logic                trig1_o,
  output logic                trig2_o,
  input  logic [PORT_W-1:0]   pa_in_i,
  output logic [PORT_W-1:0]   pa_out_o,
  output logic [PORT_W-1:0]   pa_oe_o,
  output logic [PORT_W-1:0]   pa_ie_o,
  input  logic [PORT_W-1:0]   pb_in_i
);
  logic [PORT_W-1:0] pa_lat_q, pa_dir_q;
  logic [PORT_W-1:0] pa_sync, pb_sync, pa_rd;
  logic              wr_en, rd_en;
  port_ofs_e         ofs;

  assign ofs   = port_ofs_e'(addr_i);
  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_lat_q <= '0;
      pa_dir_q <= '0;
    end else if (wr_en) begin
      case (ofs)
        OFS_PA_DATA: pa_lat_q <= wdata_i;
        OFS_PA_DIR:  pa_dir_q <= wdata_i & DIR_MASK;
        default: ;  // port B and unused offset: ignored
      endcase
    end
  end

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STG)) u_pa_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pa_in_i), .q_o(pa_sync)
  );

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STG)) u_pb_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pb_in_i), .q_o(pb_sync)
  );

  gpio_pa_pinmux #(
    .W(PORT_W), .MUX_BITS(MUX_BITS), .TRIG1_BIT(TRIG1_BIT), .TRIG2_BIT(TRIG2_BIT)
  ) u_pinmux (
    .dir_i       (pa_dir_q),
    .lat_i       (pa_lat_q),
    .sync_i      (pa_sync),
    .ext_mux_en_i(ext_mux_en_i),
    .mux_addr_i  (mux_addr_i),
    .trig1_en_i  (trig1_en_i),
    .trig2_en_i  (trig2_en_i),
    .oe_o        (pa_oe_o),
    .out_o       (pa_out_o),
    .ie_o        (pa_ie_o),
    .rd_o        (pa_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_en) begin
      case (ofs)
        OFS_PA_DATA: rdata_o <= pa_rd;
        OFS_PA_DIR:  rdata_o <= pa_dir_q;
        OFS_PB_DATA: rdata_o <= pb_sync;
        default:     rdata_o <= '0;
      endcase
    end
  end

  assign trig1_o = trig1_en_i & pa_sync[TRIG1_BIT];
  assign trig2_o = trig2_en_i & pa_sync[TRIG2_BIT];
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       ext_mux_en_i,
  input logic [2:0] mux_addr_i,
  input logic       trig1_en_i,
  input logic       trig2_en_i,
  input logic [7:0] pa_out_o,
  input logic [7:0] pa_oe_o,
  input logic [7:0] pa_ie_o
);
  AST_MUX_OWNS_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mux_en_i |-> (pa_oe_o[2:0] == 3'b111 && pa_out_o[2:0] == mux_addr_i)); // R6
  AST_TRIG1_IS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig1_en_i |-> !pa_oe_o[3]); // R7
  AST_TRIG2_IS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig2_en_i |-> !pa_oe_o[4]); // R8
  AST_RSVD_NEVER_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_oe_o[7:5] == 3'b000); // R3
  AST_IE_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_ie_o == ~pa_oe_o); // R10
  AST_UNUSED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd3) |=> rdata_o == 8'h00); // R11
  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R11
endmodule

bind gpio_mux_port gpio_mux_port_chk chk_i (.*);

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       ext_mux_en_i = 1'b0, trig1_en_i = 1'b0, trig2_en_i = 1'b0;
  logic [2:0] mux_addr_i = '0;
  logic       trig1_o, trig2_o;
  logic [7:0] pa_in_i = '0, pa_out_o, pa_oe_o, pa_ie_o, pb_in_i = '0;

  int vectors = 0, miscompares = 0;
  logic [7:0] dir_m = '0, lat_m = '0;

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  gpio_mux_port dut_i (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 1'b0; we_i = 1'b0;
    if (a == 2'd0) lat_m = d;
    if (a == 2'd1) dir_m = d & 8'h1F;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i); req_i = 1'b0; d = rdata_o;
  endtask

  function automatic logic [7:0] exp_oe();
    logic [7:0] r = dir_m;
    if (trig1_en_i) r[3] = 1'b0;
    if (trig2_en_i) r[4] = 1'b0;
    if (ext_mux_en_i) r[2:0] = 3'b111;
    return r;
  endfunction

  function automatic logic [7:0] exp_out();
    logic [7:0] r = lat_m;
    if (ext_mux_en_i) r[2:0] = mux_addr_i;
    return r;
  endfunction

  function automatic logic [7:0] exp_pa_rd();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = dir_m[i] ? lat_m[i] : pa_in_i[i];
    if (trig1_en_i) r[3] = pa_in_i[3];
    if (trig2_en_i) r[4] = pa_in_i[4];
    if (ext_mux_en_i) r[2:0] = mux_addr_i;
    return r;
  endfunction

  task automatic check_all(string tag);
    logic [7:0] d;
    repeat (3) @(negedge clk_i);  // let synchronizers settle
    check({tag, " R2 oe"}, pa_oe_o, exp_oe());
    check({tag, " R4 out"}, pa_out_o, exp_out());
    check({tag, " R10 ie"}, pa_ie_o, ~exp_oe());
    check({tag, " R7 trig1"}, {7'd0, trig1_o}, {7'd0, trig1_en_i & pa_in_i[3]});
    check({tag, " R8 trig2"}, {7'd0, trig2_o}, {7'd0, trig2_en_i & pa_in_i[4]});
    bus_read(2'd0, d); check({tag, " R5/R6 pa read"}, d, exp_pa_rd());
    bus_read(2'd1, d); check({tag, " R3 dir read"}, d, dir_m);
    bus_read(2'd2, d); check({tag, " R9 pb read"}, d, pb_in_i);
    bus_read(2'd3, d); check({tag, " R11 unused read"}, d, 8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    void'($urandom(32'd4711));
    #1;
    check("R1 oe at reset", pa_oe_o, 8'h00);
    check("R1 rdata at reset", rdata_o, 8'h00);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 out after reset", pa_out_o, 8'h00);
    bus_read(2'd1, d); check("R1 dir after reset", d, 8'h00);

    // R3: reserved direction bits
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, d); check("R3 reserved dir bits", d, 8'h1F);
    check("R3 oe reserved pins", pa_oe_o, 8'h1F);

    // R4: latch written while inputs, then driven by direction change
    bus_write(2'd1, 8'h00);
    pa_in_i = 8'h3C;
    bus_write(2'd0, 8'hA5);
    check("R4 out while input", pa_out_o, 8'hA5);
    check("R4 oe while input", pa_oe_o, 8'h00);
    bus_write(2'd1, 8'h1F);
    check("R4 out after dir change", pa_out_o, 8'hA5);
    check_all("dir");

    // R9: port B writes ignored
    pb_in_i = 8'h96;
    bus_write(2'd2, 8'h55);
    check("R9 pa out untouched", pa_out_o, 8'hA5);
    check_all("pbw");

    // R6/R7/R8 directed: modes claim pins configured as outputs
    bus_write(2'd0, 8'h00);
    pa_in_i = 8'hFF; mux_addr_i = 3'b101;
    ext_mux_en_i = 1'b1; trig1_en_i = 1'b1; trig2_en_i = 1'b1;
    check_all("modes");

    for (int n = 0; n < 300; n++) begin
      case ($urandom_range(0, 3))
        0: bus_write(2'd0, 8'($urandom));
        1: bus_write(2'd1, 8'($urandom) | 8'h18);
        2: bus_write(2'd2, 8'($urandom));
        default: ;
      endcase
      @(negedge clk_i);
      pa_in_i = 8'($urandom); pb_in_i = 8'($urandom);
      mux_addr_i = 3'($urandom);
      ext_mux_en_i = 1'($urandom); trig1_en_i = 1'($urandom); trig2_en_i = 1'($urandom);
      check_all("rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule